// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel with Block Fill

A single DMA channel that moves words from one memory region to another over a simple word-wide master port. Software programs a byte count, a source base and a destination base into one of two buffer slots, then sets the enable bit in the control register. The channel starts with slot 0. It reads a word from the source, writes it to the destination, advances the addresses and repeats until the slot's count is used up. It then moves on to the other slot.

In fill mode the channel reads the source word only once per slot and writes that word to every destination location of the slot. This fills a block of memory with one value. When the next slot has no fresh count, the channel parks in a stall state. Writing that slot's count makes it continue, so software can keep chaining buffers by alternating between the two slots. Completion and stall events each set a sticky flag, gated by its own enable, and each flag drives an interrupt line.

Registers are word-addressed: 0 control, 1 status, 2/3 byte count slot 0/1, 4/5 source base 0/1, 6/7 destination base 0/1, 8/9 current source 0/1, 10/11 current destination 0/1.

Top module: `m2m_dma_chan`

## Requirements
- R1: After reset every register reads 0, `mem_req_o` is low and both interrupt lines are low.
- R2: In copy mode (control bit 1 = 0) a slot moves floor(count/4) words. Source and destination advance by 4 after each word, and the destination words equal the source words. The word after the block is left untouched.
- R3: In fill mode (control bit 1 = 1) the channel issues exactly one read per slot and writes that word to floor(count/4) successive destination words.
- R4: In fill mode the two low bits of both base addresses are forced to 0. Every bus address is word aligned, and the current-source register shows the aligned base.
- R5: When a slot finishes, its current-destination register (10/11) reads base + 4*words. Its current-source register (8/9) reads base + 4*words in copy mode, or the unchanged aligned base in fill mode.
- R6: Writing a slot's byte count marks that slot valid (status bit 2 for slot 0, bit 3 for slot 1). Finishing the slot clears the mark. After a slot finishes, a valid other slot runs without software action.
- R7: If the next slot is not valid, the channel stalls. The stall flag (status bit 1, output `stall_irq_o`) is set on entry only when control bit 3 is 1. Writing the awaited slot's count resumes the transfer.
- R8: Each finished slot sets the done flag (status bit 0, output `done_irq_o`) only when control bit 2 is 1.
- R9: Any write to the status register clears both flags, whatever the data.
- R10: The fill setting is captured when enable (control bit 0) rises. Changing control bit 1 while enabled has no effect on the running transfer.
- R11: Clearing enable returns the channel to idle. No further bus request is issued.
- R12: Control bits 31:4 and unused status bits read 0, and unmapped register indices read 0. A bus request keeps its address, direction and data stable until `mem_gnt_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_irq_o | output | 1 | Done flag |
| stall_irq_o | output | 1 | Stall flag |

## Verification
The hardest state to reach is a stall in the middle of a run. It has to be entered with the stall enable set, cleared by a status write, and then left by programming the other slot, while fill mode, captured at the enable edge, must survive. The bench gets there in a directed sequence. It finishes an unaligned fill on slot 0, lets the channel stall, clears the flags, then arms slot 1 and checks the second fill and the read count. A chained copy toggles the fill bit in the middle of the run. Randomized single-slot copies and fills with random bases, lengths and grant timing are compared against memory images computed by bench functions.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RD, S_WAIT, S_WR, S_STALL} dma_st_e;

  localparam logic [3:0] OFF_CTRL  = 4'd0;
  localparam logic [3:0] OFF_STAT  = 4'd1;
  localparam logic [3:0] OFF_CNT0  = 4'd2;
  localparam logic [3:0] OFF_SRC0  = 4'd4;
  localparam logic [3:0] OFF_DST0  = 4'd6;
  localparam logic [3:0] OFF_SCUR0 = 4'd8;
  localparam logic [3:0] OFF_DCUR0 = 4'd10;

  localparam int C_EN   = 0;
  localparam int C_FILL = 1;
  localparam int C_DIE  = 2;
  localparam int C_SIE  = 3;
  localparam int C_W    = 4;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [3:0]           addr_i,
  input  logic [W-1:0]         wdata_i,
  output logic [W-1:0]         rdata_o,
  output logic [C_W-1:0]       ctrl_o,
  output logic [1:0][CW-1:0]   cnt_o,
  output logic [1:0][W-1:0]    src_o,
  output logic [1:0][W-1:0]    dst_o,
  output logic [1:0]           valid_o,
  output logic                 done_f_o,
  output logic                 stall_f_o,
  input  logic                 buf_done_i,
  input  logic                 stall_enter_i,
  input  logic                 idx_i,
  input  logic [1:0][W-1:0]    scur_i,
  input  logic [1:0][W-1:0]    dcur_i
);
  logic [C_W-1:0] ctrl_q;
  logic           done_q, stall_q;
  logic           stat_wr;

  assign stat_wr = wr_i && (addr_i == OFF_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_i && addr_i == OFF_CTRL) ctrl_q <= wdata_i[C_W-1:0];
  end

  // event set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      if (buf_done_i && ctrl_q[C_DIE])         done_q <= 1'b1;
      else if (stat_wr)                        done_q <= 1'b0;
      if (stall_enter_i && ctrl_q[C_SIE])      stall_q <= 1'b1;
      else if (stat_wr)                        stall_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_slot
    logic [CW-1:0] cnt_r;
    logic [W-1:0]  src_r, dst_r;
    logic          vld_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_r <= '0;
        src_r <= '0;
        dst_r <= '0;
        vld_r <= 1'b0;
      end else begin
        if (wr_i && addr_i == OFF_CNT0 + 4'(b)) begin
          cnt_r <= wdata_i[CW-1:0];
          vld_r <= 1'b1;
        end else if (buf_done_i && idx_i == 1'(b)) begin
          vld_r <= 1'b0;
        end
        if (wr_i && addr_i == OFF_SRC0 + 4'(b)) src_r <= wdata_i;
        if (wr_i && addr_i == OFF_DST0 + 4'(b)) dst_r <= wdata_i;
      end
    end
    assign cnt_o[b]   = cnt_r;
    assign src_o[b]   = src_r;
    assign dst_o[b]   = dst_r;
    assign valid_o[b] = vld_r;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL:      rdata_o[C_W-1:0] = ctrl_q;
      OFF_STAT:      rdata_o[4:0] = {idx_i, valid_o, stall_q, done_q};
      OFF_CNT0:      rdata_o[CW-1:0] = cnt_o[0];
      OFF_CNT0 + 1:  rdata_o[CW-1:0] = cnt_o[1];
      OFF_SRC0:      rdata_o = src_o[0];
      OFF_SRC0 + 1:  rdata_o = src_o[1];
      OFF_DST0:      rdata_o = dst_o[0];
      OFF_DST0 + 1:  rdata_o = dst_o[1];
      OFF_SCUR0:     rdata_o = scur_i[0];
      OFF_SCUR0 + 1: rdata_o = scur_i[1];
      OFF_DCUR0:     rdata_o = dcur_i[0];
      OFF_DCUR0 + 1: rdata_o = dcur_i[1];
      default:       rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign done_f_o  = done_q;
  assign stall_f_o = stall_q;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16,
  localparam int NW = CW - 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 fill_i,
  input  logic [1:0]           valid_i,
  input  logic [1:0][NW-1:0]   words_i,
  input  logic [1:0][W-1:0]    src_i,
  input  logic [1:0][W-1:0]    dst_i,
  output logic                 req_o,
  output logic                 we_o,
  output logic [W-1:0]         addr_o,
  output logic [W-1:0]         wdata_o,
  input  logic                 gnt_i,
  input  logic                 rvalid_i,
  input  logic [W-1:0]         rdata_i,
  output logic                 buf_done_o,
  output logic                 stall_enter_o,
  output logic                 idx_o,
  output logic                 fill_o,
  output logic [1:0][W-1:0]    scur_o,
  output logic [1:0][W-1:0]    dcur_o
);
  dma_st_e            st_q;
  logic               idx_q, fill_q;
  logic [NW-1:0]      left_q;
  logic [W-1:0]       data_q;
  logic [1:0][W-1:0]  scur_q, dcur_q;
  logic               last_wr, load_empty;

  function automatic logic [W-1:0] align_f(input logic [W-1:0] a, input logic f);
    return f ? {a[W-1:2], 2'b00} : a;
  endfunction

  assign req_o   = (st_q == S_RD) || (st_q == S_WR);
  assign we_o    = (st_q == S_WR);
  assign addr_o  = we_o ? dcur_q[idx_q] : scur_q[idx_q];
  assign wdata_o = data_q;

  assign last_wr    = (st_q == S_WR) && gnt_i && (left_q == NW'(1));
  assign load_empty = (st_q == S_LOAD) && valid_i[idx_q] && (words_i[idx_q] == '0);
  assign buf_done_o    = en_i && (last_wr || load_empty);
  assign stall_enter_o = en_i && (st_q == S_LOAD) && !valid_i[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= 1'b0;
      fill_q <= 1'b0;
      left_q <= '0;
      data_q <= '0;
      scur_q <= '0;
      dcur_q <= '0;
    end else if (!en_i) begin
      st_q <= S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          fill_q <= fill_i;  // configuration captured at enable rise
          idx_q  <= 1'b0;
          st_q   <= S_LOAD;
        end
        S_LOAD: begin
          if (!valid_i[idx_q]) begin
            st_q <= S_STALL;
          end else begin
            scur_q[idx_q] <= align_f(src_i[idx_q], fill_q);
            dcur_q[idx_q] <= align_f(dst_i[idx_q], fill_q);
            left_q        <= words_i[idx_q];
            if (words_i[idx_q] == '0) idx_q <= ~idx_q;
            else                      st_q  <= S_RD;
          end
        end
        S_RD:   if (gnt_i) st_q <= S_WAIT;
        S_WAIT: if (rvalid_i) begin
          data_q <= rdata_i;
          st_q   <= S_WR;
        end
        S_WR: if (gnt_i) begin
          dcur_q[idx_q] <= dcur_q[idx_q] + W'(4);
          if (!fill_q) scur_q[idx_q] <= scur_q[idx_q] + W'(4);
          left_q <= left_q - NW'(1);
          if (left_q == NW'(1)) begin
            idx_q <= ~idx_q;
            st_q  <= S_LOAD;
          end else begin
            st_q <= fill_q ? S_WR : S_RD;
          end
        end
        S_STALL: if (valid_i[idx_q]) st_q <= S_LOAD;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign fill_o = fill_q;
  assign scur_o = scur_q;
  assign dcur_o = dcur_q;
endmodule

// File: rtl/m2m_dma_chan.sv
module m2m_dma_chan
  import dma_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_wr_i,
  input  logic [3:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic         mem_gnt_i,
  input  logic         mem_rvalid_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         done_irq_o,
  output logic         stall_irq_o
);
  localparam int NW = CW - 2;

  logic [C_W-1:0]      ctrl;
  logic [1:0][CW-1:0]  cnt;
  logic [1:0][NW-1:0]  words;
  logic [1:0][W-1:0]   src, dst, scur, dcur;
  logic [1:0]          valid;
  logic                buf_done, stall_enter, idx, fill_act;
  logic                enable, done_ie, stall_ie;

  assign enable   = ctrl[C_EN];
  assign done_ie  = ctrl[C_DIE];
  assign stall_ie = ctrl[C_SIE];

  for (genvar b = 0; b < 2; b++) begin : g_words
    assign words[b] = cnt[b][CW-1:2];
  end

  dma_regs #(.W(W), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl), .cnt_o(cnt), .src_o(src), .dst_o(dst), .valid_o(valid),
    .done_f_o(done_irq_o), .stall_f_o(stall_irq_o),
    .buf_done_i(buf_done), .stall_enter_i(stall_enter), .idx_i(idx),
    .scur_i(scur), .dcur_i(dcur)
  );

  dma_engine #(.W(W), .CW(CW)) u_eng (
    .clk_i, .rst_ni,
    .en_i(enable), .fill_i(ctrl[C_FILL]), .valid_i(valid), .words_i(words),
    .src_i(src), .dst_i(dst),
    .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o),
    .gnt_i(mem_gnt_i), .rvalid_i(mem_rvalid_i), .rdata_i(mem_rdata_i),
    .buf_done_o(buf_done), .stall_enter_o(stall_enter), .idx_o(idx), .fill_o(fill_act),
    .scur_o(scur), .dcur_o(dcur)
  );
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req,
  input logic         gnt,
  input logic         we,
  input logic [W-1:0] addr,
  input logic [W-1:0] wdata,
  input logic         fill_act,
  input logic         enable,
  input logic         done_ie,
  input logic         stall_ie,
  input logic         done_irq,
  input logic         stall_irq
);
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && !gnt && enable |=> req && $stable(addr) && $stable(we) && $stable(wdata));

  a_r4_fill_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && fill_act |-> addr[1:0] == 2'b00);

  a_r8_done_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_irq) |-> $past(done_ie));

  a_r7_stall_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_irq) |-> $past(stall_ie));

  a_r11_off_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |=> !req);
endmodule

bind m2m_dma_chan dma_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req(mem_req_o), .gnt(mem_gnt_i), .we(mem_we_o), .addr(mem_addr_o), .wdata(mem_wdata_o),
  .fill_act(fill_act), .enable(enable), .done_ie(done_ie), .stall_ie(stall_ie),
  .done_irq(done_irq_o), .stall_irq(stall_irq_o)
);

// File: tb/tb_m2m_dma_chan.sv
`timescale 1ns/1ps
module tb_m2m_dma_chan;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req, we, gnt = 0, rv = 0, dirq, sirq;
  logic [31:0] addr, wdata, rdat = 0;
  logic [31:0] mem [0:1023];
  int          rd_cnt = 0, mis_cnt = 0;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  m2m_dma_chan dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_gnt_i(gnt), .mem_rvalid_i(rv), .mem_rdata_i(rdat),
    .done_irq_o(dirq), .stall_irq_o(sirq)
  );

  // memory model: random grant, one-cycle read latency
  always @(posedge clk) begin
    rv <= 1'b0;
    if (req && gnt) begin
      if (we) mem[addr[11:2]] <= wdata;
      else begin
        rdat   <= mem[addr[11:2]];
        rv     <= 1'b1;
        rd_cnt <= rd_cnt + 1;
      end
      if (dut.fill_act && addr[1:0] != 2'b00) mis_cnt <= mis_cnt + 1;
    end
    gnt <= ($urandom % 4) != 0;
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_irq(input bit stall, output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ((stall ? sirq : dirq) === 1'b1) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] end_addr(input logic [31:0] base, input bit fill, input int n);
    logic [31:0] b = fill ? {base[31:2], 2'b00} : base;
    return b + 32'(4 * n);
  endfunction

  task automatic stop_clear();
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0);
  endtask

  // single slot-0 run with done enabled; checks data, sentinel, current regs, reads
  task automatic run_buf0(input bit fill, input logic [31:0] s, input logic [31:0] d,
                          input int n, input int xb);
    logic [31:0] ex [0:63];
    logic [31:0] v;
    int          r0, mm, sw, dw;
    bit          ok;
    string       rq;
    sw = int'(s >> 2); dw = int'(d >> 2);
    for (int i = 0; i < n; i++) ex[i] = fill ? mem[sw] : mem[sw + i];
    for (int i = 0; i <= n; i++) mem[dw + i] = 32'hDEAD_0000 + i;
    r0 = rd_cnt;
    wr(4'd4, s); wr(4'd6, d); wr(4'd2, 32'(4 * n + xb));
    wr(4'd0, {28'h0, 4'b0101} | (fill ? 32'h2 : 32'h0));
    wait_irq(0, ok);
    rq = fill ? "R3" : "R2";
    chk(ok, "R8", 32'(dirq), 1);
    mm = 0;
    for (int i = 0; i < n; i++) if (mem[dw + i] !== ex[i]) mm++;
    chk(mm == 0, rq, 32'(mm), 0);
    chk(mem[dw + n] === 32'hDEAD_0000 + n, "R2", mem[dw + n], 32'hDEAD_0000 + n);
    rd(4'd10, v);
    chk(v === end_addr(d, fill, n), "R5", v, end_addr(d, fill, n));
    rd(4'd8, v);
    if (fill) chk(v === {s[31:2], 2'b00}, "R4", v, {s[31:2], 2'b00});
    else      chk(v === end_addr(s, 0, n), "R5", v, end_addr(s, 0, n));
    if (fill) chk(rd_cnt - r0 == 1, "R3", 32'(rd_cnt - r0), 1);
    stop_clear();
  endtask

  initial begin
    logic [31:0] v;
    bit          ok;
    int          m0, r0, mm, viol;
    logic [31:0] fw;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    mm = 0;
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      if (v !== 32'h0) mm++;
    end
    chk(mm == 0, "R1", 32'(mm), 0);
    chk(req === 1'b0 && dirq === 1'b0 && sirq === 1'b0, "R1", {29'h0, req, dirq, sirq}, 0);

    // R12: reserved bits and unmapped indices
    wr(4'd0, 32'hFFFF_FFF0);
    rd(4'd0, v); chk(v === 32'h0, "R12", v, 0);
    rd(4'd12, v); chk(v === 32'h0, "R12", v, 0);
    rd(4'd1, v); chk(v[31:5] === '0, "R12", v, 0);

    // R2 R5 R8: directed copy with odd byte count, no stall enable
    run_buf0(0, 32'h0000_0040, 32'h0000_0900, 9, 3);
    rd(4'd1, v); chk(v[1:0] === 2'b00, "R9", {30'h0, v[1:0]}, 0);

    // R8: done enable clear -> no flag
    wr(4'd4, 32'h80); wr(4'd6, 32'hA00); wr(4'd2, 32'd12);
    wr(4'd0, 32'h1);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(4'd1, v);
      if (v[2] == 1'b0) begin ok = 1; break; end
    end
    chk(ok && dirq === 1'b0 && v[0] === 1'b0, "R8", {31'h0, dirq}, 0);
    repeat (5) @(negedge clk);
    chk(sirq === 1'b0, "R7", {31'h0, sirq}, 0);
    stop_clear();

    // R3 R4 R7 R9: unaligned fill, stall, clear, resume on slot 1
    m0 = mis_cnt; r0 = rd_cnt; fw = mem[32'h203 >> 2];
    for (int i = 0; i < 6; i++) mem[(32'hC00 >> 2) + i] = 32'h0;
    wr(4'd4, 32'h203); wr(4'd6, 32'hC02); wr(4'd2, 32'd20);
    wr(4'd0, 32'hF);
    wait_irq(1, ok);
    chk(ok, "R7", {31'h0, sirq}, 1);
    chk(rd_cnt - r0 == 1, "R3", 32'(rd_cnt - r0), 1);
    mm = 0;
    for (int i = 0; i < 5; i++) if (mem[(32'hC00 >> 2) + i] !== fw) mm++;
    chk(mm == 0 && mem[(32'hC00 >> 2) + 5] === 32'h0, "R3", 32'(mm), 0);
    rd(4'd8, v); chk(v === 32'h200, "R4", v, 32'h200);
    rd(4'd10, v); chk(v === 32'hC14, "R5", v, 32'hC14);
    wr(4'd1, 32'h0);
    rd(4'd1, v); chk(v[1:0] === 2'b00 && sirq === 1'b0, "R9", {30'h0, v[1:0]}, 0);
    fw = mem[32'h301 >> 2];
    wr(4'd5, 32'h301); wr(4'd7, 32'hD03); wr(4'd3, 32'd12);
    wait_irq(1, ok);
    chk(ok, "R7", {31'h0, sirq}, 1);
    mm = 0;
    for (int i = 0; i < 3; i++) if (mem[(32'hD00 >> 2) + i] !== fw) mm++;
    chk(mm == 0, "R6", 32'(mm), 0);
    chk(rd_cnt - r0 == 2, "R3", 32'(rd_cnt - r0), 2);
    rd(4'd11, v); chk(v === 32'hD0C, "R5", v, 32'hD0C);
    rd(4'd9, v); chk(v === 32'h300, "R4", v, 32'h300);
    chk(mis_cnt == m0, "R4", 32'(mis_cnt - m0), 0);
    stop_clear();

    // R6 R10: both slots preset, fill bit toggled while running
    wr(4'd4, 32'h100); wr(4'd6, 32'h400); wr(4'd2, 32'd28);
    wr(4'd5, 32'h180); wr(4'd7, 32'h500); wr(4'd3, 32'd36);
    wr(4'd0, 32'h9);
    repeat (4) @(negedge clk);
    wr(4'd0, 32'hB);
    wait_irq(1, ok);
    chk(ok, "R6", {31'h0, sirq}, 1);
    mm = 0;
    for (int i = 0; i < 7; i++) if (mem[(32'h400 >> 2) + i] !== mem[(32'h100 >> 2) + i]) mm++;
    for (int i = 0; i < 9; i++) if (mem[(32'h500 >> 2) + i] !== mem[(32'h180 >> 2) + i]) mm++;
    chk(mm == 0, "R10", 32'(mm), 0);
    rd(4'd1, v); chk(v[3:2] === 2'b00, "R6", {30'h0, v[3:2]}, 0);
    stop_clear();

    // constrained random single-slot runs
    for (int it = 0; it < 8; it++) begin
      bit f;
      logic [31:0] s, d;
      f = 1'($urandom % 2);
      s = 32'(($urandom % 64) * 4) + (f ? 32'($urandom % 4) : 32'h0);
      d = 32'h800 + 32'(($urandom % 64) * 4) + (f ? 32'($urandom % 4) : 32'h0);
      run_buf0(f, s, d, 1 + int'($urandom % 24), int'($urandom % 4));
    end

    // R11: abort by clearing enable
    wr(4'd4, 32'h0); wr(4'd6, 32'h400); wr(4'd2, 32'd800);
    wr(4'd0, 32'h1);
    repeat (40) @(negedge clk);
    wr(4'd0, 32'h0);
    @(negedge clk);
    viol = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (req !== 1'b0) viol++;
    end
    chk(viol == 0, "R11", 32'(viol), 0);
    rd(4'd10, v); chk(v < 32'h400 + 32'd800, "R11", v, 32'h720);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule